// File: doc/BRIEF.md
# Strap-Sampled Status LED Controller

This block runs five dual-role pads. While the hardware or power-on reset is active each pad is only an input. When reset is released, the block takes the level on each pad as one bit of a 5-bit management address. After that it drives each pad as a status LED output. The LED lights when the pad drives the opposite of its captured level, so a pad strapped low through an LED drives high to light it, and a pad strapped high drives low.

The five pads carry, in bit order:

- bit 0: link activity
- bit 1: collision
- bit 2: link integrity
- bit 3: transmit data
- bit 4: receive data

Activity, collision, transmit and receive arrive as single-cycle events. Each one is stretched to a minimum on-time of `HOLD_CYCLES` clocks so that it can be seen on an LED. Link integrity is shown as a level.

A soft reset input blanks all status but keeps the captured address and the pad direction. A captured address of zero requests that the MII outputs be tri-stated.

Top module: `strap_led_ctrl`

## Requirements
- R1: While `rst_ni` is low, `pin_oe_o` is 0, `mgmt_addr_o` is 0 and `mii_tristate_o` is 1.
- R2: The rising edges of `clk_i` after `rst_ni` goes high are counted from 1. `mgmt_addr_o` stays 0 through edge 2. At edge 3 it loads `pin_i`, with bit i taken from pad i (0 activity, 1 collision, 2 link, 3 transmit, 4 receive).
- R3: `pin_oe_o` becomes all ones at edge 4, one edge after the capture. It then stays all ones until `rst_ni` goes low.
- R4: Once the outputs are enabled, a pad whose status is asserted drives the inverse of its address bit. A pad whose status is deasserted drives its address bit.
- R5: An event on activity, collision, transmit or receive sampled at edge k asserts that pad's status after edges k through k+HOLD_CYCLES-1 and releases it at edge k+HOLD_CYCLES. A new event restarts the window.
- R6: Link integrity follows `link_up_i` with one edge of latency and is not stretched.
- R7: Once captured, `mgmt_addr_o` is never re-sampled from `pin_i` until the next `rst_ni` assertion. This holds through soft reset, and `pin_oe_o` keeps its value during soft reset.
- R8: An edge that samples `soft_rst_i` high clears all five statuses and ignores all status inputs, so every pad drives its address bit.
- R9: `mii_tristate_o` is 1 exactly when `mgmt_addr_o` is 0.
- R10: While `pin_oe_o` is 0, `pin_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous hardware/power-on reset |
| soft_rst_i | input | 1 | Soft reset; blanks status only |
| pin_i | input | 5 | Pad input levels (strap values) |
| evt_act_i | input | 1 | Link activity event pulse |
| evt_col_i | input | 1 | Collision event pulse |
| link_up_i | input | 1 | Link integrity level |
| evt_tx_i | input | 1 | Transmit data event pulse |
| evt_rx_i | input | 1 | Receive data event pulse |
| pin_o | output | 5 | Pad output values |
| pin_oe_o | output | 5 | Pad output enables |
| mgmt_addr_o | output | 5 | Captured management address |
| mii_tristate_o | output | 1 | Request to tri-state the MII outputs |

## Verification
The assertions assume that `pin_i` is stable around the capture edge. They also assume that `rst_ni` is the only source of re-capture, so that once the enables are up the address must not move. The stimulus holds each strap value from reset assertion until after the capture edge, then inverts the pads so that any re-sampling would show. Status inputs change only on falling clock edges. The bench sweeps all 32 strap values with a six-cycle hold so that every pulse window ends within the run.

// File: rtl/strap_led_pkg.sv
package strap_led_pkg;
  localparam int unsigned NUM_PINS = 5;

  typedef enum logic [2:0] {
    PIN_ACT  = 3'd0,
    PIN_COL  = 3'd1,
    PIN_LINK = 3'd2,
    PIN_TX   = 3'd3,
    PIN_RX   = 3'd4
  } pin_idx_e;
endpackage

// File: rtl/strap_rst_sync.sv
module strap_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int unsigned WIDTH = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] addr_o,
  output logic             oe_o
);
  logic             cap_q;
  logic             oe_q;
  logic [WIDTH-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= 1'b0;
      oe_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      if (!cap_q) begin
        addr_q <= pin_i;
        cap_q  <= 1'b1;
      end
      oe_q <= cap_q;  // enables follow capture by one edge
    end
  end

  assign addr_o = addr_q;
  assign oe_o   = oe_q;
endmodule

// File: rtl/led_pulse_stretch.sv
module led_pulse_stretch #(
  parameter int unsigned HOLD_CYCLES = 65536,
  parameter bit          LEVEL_MODE  = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic evt_i,
  output logic act_o
);
  localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1);

  if (LEVEL_MODE) begin : g_level
    logic lvl_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_q <= 1'b0;
      else         lvl_q <= evt_i & ~clr_i;
    end
    assign act_o = lvl_q;
  end else begin : g_stretch
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               cnt_q <= '0;
      else if (clr_i)            cnt_q <= '0;
      else if (evt_i)            cnt_q <= CNT_W'(HOLD_CYCLES);
      else if (cnt_q != '0)      cnt_q <= cnt_q - CNT_W'(1);
    end
    assign act_o = (cnt_q != '0);
  end
endmodule

// File: rtl/strap_led_ctrl.sv
module strap_led_ctrl
  import strap_led_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 65536
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                soft_rst_i,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                evt_act_i,
  input  logic                evt_col_i,
  input  logic                link_up_i,
  input  logic                evt_tx_i,
  input  logic                evt_rx_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic [NUM_PINS-1:0] mgmt_addr_o,
  output logic                mii_tristate_o
);
  logic                rst_sync_n;
  logic                oe;
  logic [NUM_PINS-1:0] addr;
  logic [NUM_PINS-1:0] evt_vec;
  logic [NUM_PINS-1:0] status;

  strap_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  strap_capture #(.WIDTH(NUM_PINS)) i_capture (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .pin_i  (pin_i),
    .addr_o (addr),
    .oe_o   (oe)
  );

  always_comb begin
    evt_vec           = '0;
    evt_vec[PIN_ACT]  = evt_act_i;
    evt_vec[PIN_COL]  = evt_col_i;
    evt_vec[PIN_LINK] = link_up_i;
    evt_vec[PIN_TX]   = evt_tx_i;
    evt_vec[PIN_RX]   = evt_rx_i;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chan
    led_pulse_stretch #(
      .HOLD_CYCLES (HOLD_CYCLES),
      .LEVEL_MODE  (i == int'(PIN_LINK))
    ) i_stretch (
      .clk_i  (clk_i),
      .rst_ni (rst_sync_n),
      .clr_i  (soft_rst_i),
      .evt_i  (evt_vec[i]),
      .act_o  (status[i])
    );
  end

  // lit level is the inverse of the strap
  assign pin_o          = oe ? (addr ^ status) : '0;
  assign pin_oe_o       = {NUM_PINS{oe}};
  assign mgmt_addr_o    = addr;
  assign mii_tristate_o = (addr == '0);
endmodule

// File: rtl/strap_led_chk.sv
module strap_led_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       soft_rst_i,
  input logic       evt_act_i,
  input logic       link_up_i,
  input logic [4:0] pin_o,
  input logic [4:0] pin_oe_o,
  input logic [4:0] mgmt_addr_o
);
  // R3
  oe_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o != '0) |=> (pin_oe_o == '1));

  // R7
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o == '1) |=> $stable(mgmt_addr_o));

  // R8
  soft_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o == '1 && soft_rst_i) |=> (pin_o == mgmt_addr_o));

  // R6
  link_lit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o == '1 && link_up_i && !soft_rst_i) |=> (pin_o[2] != mgmt_addr_o[2]));

  // R5
  act_lit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o == '1 && evt_act_i && !soft_rst_i) |=> (pin_o[0] != mgmt_addr_o[0]));

  // R10
  always_comb begin
    if (rst_ni && pin_oe_o == '0) oe_low_pin_chk: assert (pin_o == '0);
  end
endmodule

bind strap_led_ctrl strap_led_chk i_chk (.*);

// File: tb/test_strap_led_ctrl.sv
module test_strap_led_ctrl;
  localparam int unsigned H = 6;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       soft_rst_i = 1'b0;
  logic [4:0] pin_i = '0;
  logic [4:0] evt = '0;
  logic [4:0] pin_o, pin_oe_o, mgmt_addr_o;
  logic       mii_tristate_o;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #4 clk_i = ~clk_i;

  strap_led_ctrl #(.HOLD_CYCLES(H)) i_strap_led_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .soft_rst_i     (soft_rst_i),
    .pin_i          (pin_i),
    .evt_act_i      (evt[0]),
    .evt_col_i      (evt[1]),
    .link_up_i      (evt[2]),
    .evt_tx_i       (evt[3]),
    .evt_rx_i       (evt[4]),
    .pin_o          (pin_o),
    .pin_oe_o       (pin_oe_o),
    .mgmt_addr_o    (mgmt_addr_o),
    .mii_tristate_o (mii_tristate_o)
  );

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic chk(input string rid, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rid, act, exp);
    end
  endtask

  task automatic do_reset(input logic [4:0] v);
    tick();
    rst_ni = 1'b0; pin_i = v; evt = '0; soft_rst_i = 1'b0;
    tick(); tick();
    chk("R1 oe", 32'(pin_oe_o), 0);
    chk("R1 addr", 32'(mgmt_addr_o), 0);
    chk("R1 tristate", 32'(mii_tristate_o), 1);
    chk("R10 pin in reset", 32'(pin_o), 0);
    rst_ni = 1'b1;
    tick(); tick();
    chk("R2 no early capture", 32'(mgmt_addr_o), 0);
    tick();
    chk("R2 capture", 32'(mgmt_addr_o), 32'(v));
    chk("R3 oe late", 32'(pin_oe_o), 0);
    chk("R10 pin before oe", 32'(pin_o), 0);
    chk("R9 tristate", 32'(mii_tristate_o), 32'(v == 5'd0));
    pin_i = ~v;
    tick();
    chk("R3 oe up", 32'(pin_oe_o), 32'h1f);
    chk("R4 dark", 32'(pin_o), 32'(v));
    chk("R7 no resample", 32'(mgmt_addr_o), 32'(v));
  endtask

  task automatic pulse(input logic [4:0] v, input int ch);
    evt[ch] = 1'b1;
    tick();
    evt[ch] = 1'b0;
    for (int j = 0; j < int'(H); j++) begin
      chk("R5 lit", 32'(pin_o), 32'(v ^ (5'd1 << ch)));
      tick();
    end
    chk("R5 expired", 32'(pin_o), 32'(v));
  endtask

  initial begin
    for (int s = 0; s < 32; s++) begin
      logic [4:0] v;
      v = 5'(s);
      do_reset(v);
      for (int ch = 0; ch < 5; ch++) begin
        if (ch != 2) pulse(v, ch);
      end
      // R6 link level
      evt[2] = 1'b1;
      tick();
      chk("R6 link lit", 32'(pin_o), 32'(v ^ 5'b00100));
      evt[2] = 1'b0;
      tick();
      chk("R6 link dark", 32'(pin_o), 32'(v));
      // R8 soft reset
      evt[0] = 1'b1;
      tick();
      evt[0] = 1'b0;
      chk("R4 act lit", 32'(pin_o), 32'(v ^ 5'b00001));
      soft_rst_i = 1'b1; evt[2] = 1'b1; evt[1] = 1'b1;
      tick();
      evt[1] = 1'b0;
      chk("R8 soft dark", 32'(pin_o), 32'(v));
      chk("R7 soft oe", 32'(pin_oe_o), 32'h1f);
      chk("R7 soft addr", 32'(mgmt_addr_o), 32'(v));
      tick();
      chk("R8 soft dark hold", 32'(pin_o), 32'(v));
      soft_rst_i = 1'b0;
      tick();
      chk("R6 link after soft", 32'(pin_o), 32'(v ^ 5'b00100));
      evt[2] = 1'b0;
      tick();
      chk("R8 stretch cleared", 32'(pin_o), 32'(v));
    end
    // R5 retrigger restarts the window
    begin
      logic [4:0] v;
      v = 5'b10110;
      do_reset(v);
      evt[3] = 1'b1;
      tick();
      evt[3] = 1'b0;
      tick(); tick(); tick();
      evt[3] = 1'b1;
      tick();
      evt[3] = 1'b0;
      for (int j = 0; j < int'(H); j++) begin
        chk("R5 retrigger lit", 32'(pin_o), 32'(v ^ 5'b01000));
        tick();
      end
      chk("R5 retrigger end", 32'(pin_o), 32'(v));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule